// File: doc/BRIEF.md
# Peripheral Interrupt Flag Unit

This block collects the interrupt sources of one peripheral and turns them into a single request line for the system's interrupt controller. Each source input is a one-cycle condition strobe from inside the peripheral. A strobe latches into a sticky flag bit, and the flag stays set until software clears it. Each flag has its own enable bit. The request output is high while at least one flag is set and its enable bit is also set.

Software reaches the block over a simple register port. Each access is a single cycle with separate read and write strobes and a 2-bit register select. Select 0 is the flag register: reading it returns the flags, and writing ones clears the matching flags. Select 1 sets enable bits, and select 2 clears them. Both of these read back the current enable mask. Because enables change only by setting or clearing bits, one bit can be changed without a read-modify-write, and so without a race against another writer. Select 3 is unused.

The design has no state machine. The register select is decoded as an enumerated value with a unique case, and the flag and enable banks are flop arrays built per bit.

Top module: `irqf_top`

## Requirements
- R1: While reset is held, and after it is released, every flag and every enable bit is 0, and `irq_o` is 0.
- R2: When `evt_i[i]` is 1 at a rising clock edge, flag i is 1 from that edge on. It stays 1 after the strobe ends and over idle cycles.
- R3: A write with select 0 clears each flag whose `wdata` bit is 1. Flags whose `wdata` bit is 0 keep their value.
- R4: If an event and a select-0 clear hit the same flag at the same edge, the flag ends up 1.
- R5: A write with select 1 sets each enable bit whose `wdata` bit is 1. Enable bits whose `wdata` bit is 0 keep their value.
- R6: A write with select 2 clears each enable bit whose `wdata` bit is 1. Enable bits whose `wdata` bit is 0 keep their value.
- R7: Read data depends on the select while `rd_en` is 1:
  - select 0 returns the flags;
  - select 1 and select 2 both return the enable mask;
  - select 3 returns 0, and a write to select 3 changes nothing.
  
  While `rd_en` is 0, `rdata` is 0. Read data is combinational in the same cycle as the strobe.
- R8: `irq_o` is the OR, over all sources, of flag AND enable. It is combinational from the registered state. It goes high in the cycle after the edge that makes some flag/enable pair both 1. It drops in the cycle after the edge that clears the last such pair, whether a flag clear or an enable clear does it.
- R9: A flag is set by its event even when its enable bit is 0. It is visible on a select-0 read, but it does not raise `irq_o` until it is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Per-source condition strobes |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 2 | Register select (0 flags, 1 enable-set, 2 enable-clear, 3 unused) |
| wdata | input | N_SRC | Write data, one bit per source |
| rdata | output | N_SRC | Read data, 0 when no read is strobed |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every state change here takes exactly one clock edge. An event strobe or register write held across one rising edge becomes visible on a read, and on `irq_o`, in the cycle right after that edge. Read data is combinational, so it is valid during the same cycle as the read strobe. The bench drives inputs 1 ns after each rising edge and compares `rdata` and `irq_o` at the following falling edge. Each expected value queued by a driver task therefore refers to the state after all edges that task has already spanned. Same-edge collisions (event against clear) are driven together within one cycle, so the winner is judged on the very next read.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_FLAG  = 2'd0,
        SEL_ENSET = 2'd1,
        SEL_ENCLR = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irqf_regdec.sv
module irqf_regdec
    import irqf_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] addr,
    output reg_sel_e         sel,
    output logic             we_flag_clr,
    output logic             we_en_set,
    output logic             we_en_clr
);
    assign sel = reg_sel_e'(addr);

    always_comb begin
        we_flag_clr = 1'b0;
        we_en_set   = 1'b0;
        we_en_clr   = 1'b0;
        unique case (sel)
            SEL_FLAG:  we_flag_clr = wr_en;
            SEL_ENSET: we_en_set   = wr_en;
            SEL_ENCLR: we_en_clr   = wr_en;
            SEL_NONE:  ;
        endcase
    end
endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [N_SRC-1:0] flag_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (evt_i[i])
                flag_q[i] <= 1'b1;           // event beats a same-edge clear
            else if (clr_we && clr_mask[i])
                flag_q[i] <= 1'b0;
        end
    end

    // R2: a set flag is lost only through a software clear
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ((($past(flag_q) & ~($past(clr_we) ? $past(clr_mask) : '0)) & ~flag_q) == '0));

    // R4: every strobed source shows a set flag after the edge
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flag_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/irqf_enable_bank.sv
module irqf_enable_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] en_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_en
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_q[i] <= 1'b0;
            else if (set_we && wdata[i])
                en_q[i] <= 1'b1;
            else if (clr_we && wdata[i])
                en_q[i] <= 1'b0;
        end
    end

    p_enset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set_we)) |-> ((en_q & $past(wdata)) == $past(wdata)));

    p_enclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_we)) |-> ((en_q & $past(wdata)) == '0));
endmodule

// File: rtl/irqf_top.sv
module irqf_top
    import irqf_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] rdata,
    output logic             irq_o
);
    reg_sel_e         sel;
    logic             we_flag_clr;
    logic             we_en_set;
    logic             we_en_clr;
    logic [N_SRC-1:0] flag_w;
    logic [N_SRC-1:0] en_w;

    irqf_regdec u_dec (
        .wr_en       (wr_en),
        .addr        (addr),
        .sel         (sel),
        .we_flag_clr (we_flag_clr),
        .we_en_set   (we_en_set),
        .we_en_clr   (we_en_clr)
    );

    irqf_flag_bank #(.N_SRC(N_SRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_we   (we_flag_clr),
        .clr_mask (wdata),
        .flag_q   (flag_w)
    );

    irqf_enable_bank #(.N_SRC(N_SRC)) u_enables (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (we_en_set),
        .clr_we (we_en_clr),
        .wdata  (wdata),
        .en_q   (en_w)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_FLAG:  rdata = flag_w;
                SEL_ENSET: rdata = en_w;
                SEL_ENCLR: rdata = en_w;
                SEL_NONE:  rdata = '0;
            endcase
        end
    end

    assign irq_o = |(flag_w & en_w);

    // R8: a request rises only after an event or an enable-set write
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(irq_o)) |->
        (($past(evt_i) != '0) || ($past(wr_en) && ($past(addr) == 2'd1))));
endmodule

// File: tb/irqf_top_test.sv
module irqf_top_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq_o;

    logic mon_irq = 1'b0;
    logic mon_idle = 1'b0;
    bit   done = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        int           kind;   // 0 rdata on read, 1 irq, 2 rdata while idle
        logic [N-1:0] exp;
        string        req;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    irqf_top #(.N_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        if (rd_en || mon_irq || mon_idle) begin
            item_t it;
            logic [N-1:0] act;
            if (sb.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL scoreboard empty: act rdata=%h irq=%b exp none", rdata, irq_o);
            end else begin
                it = sb.pop_front();
                act = (it.kind == 1) ? {{(N-1){1'b0}}, irq_o} : rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        evt_i = m;
        step();
        evt_i = '0;
    endtask

    task automatic pulse_and_clear(input logic [N-1:0] m);
        evt_i = m; wr_en = 1'b1; addr = 2'd0; wdata = m;
        step();
        evt_i = '0; wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [N-1:0] e, input string r);
        item_t it;
        it.kind = 0; it.exp = e; it.req = r;
        sb.push_back(it);
        rd_en = 1'b1; addr = a;
        step();
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string r);
        item_t it;
        it.kind = 1; it.exp = {{(N-1){1'b0}}, e}; it.req = r;
        sb.push_back(it);
        mon_irq = 1'b1;
        step();
        mon_irq = 1'b0;
    endtask

    task automatic chk_idle(input string r);
        item_t it;
        it.kind = 2; it.exp = '0; it.req = r;
        sb.push_back(it);
        mon_idle = 1'b1;
        step();
        mon_idle = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        rd_en = 1'b1; addr = 2'd0;
        #2;
        n_vec++;
        if (rdata !== '0 || irq_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 during reset: actual %h/%b expected 00/0", rdata, irq_o);
        end
        rd_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 after reset
        rd(2'd0, 8'h00, "R1 flags");
        rd(2'd1, 8'h00, "R1 enables");
        chk_irq(1'b0, "R1 irq");

        // R2 / R9
        pulse(8'h05);
        rd(2'd0, 8'h05, "R2 flag set");
        step(); step();
        rd(2'd0, 8'h05, "R2 flag sticky");
        chk_irq(1'b0, "R9 flag without enable");

        // R5 / R7 / R8
        wr(2'd1, 8'h04);
        rd(2'd1, 8'h04, "R5 enable set");
        rd(2'd2, 8'h04, "R7 enclr reads mask");
        chk_irq(1'b1, "R8 irq high");
        wr(2'd1, 8'h00);
        rd(2'd1, 8'h04, "R5 zero write no effect");

        // R3
        wr(2'd0, 8'h01);
        rd(2'd0, 8'h04, "R3 partial clear");
        chk_irq(1'b1, "R3 irq kept");
        wr(2'd0, 8'h04);
        chk_irq(1'b0, "R8 irq drops after clear");
        rd(2'd0, 8'h00, "R3 all clear");

        // R4
        pulse_and_clear(8'h80);
        rd(2'd0, 8'h80, "R4 set wins");

        // R6 / R8
        wr(2'd1, 8'h80);
        chk_irq(1'b1, "R8 irq from bit7");
        wr(2'd2, 8'h00);
        rd(2'd1, 8'h84, "R6 zero write no effect");
        wr(2'd2, 8'h80);
        rd(2'd1, 8'h04, "R6 enable cleared");
        chk_irq(1'b0, "R8 irq drops on disable");

        // R7 unused select
        wr(2'd3, 8'hFF);
        rd(2'd1, 8'h04, "R7 select3 write ignored enables");
        rd(2'd0, 8'h80, "R7 select3 write ignored flags");
        rd(2'd3, 8'h00, "R7 select3 reads zero");
        chk_idle("R7 rdata zero without read");

        // R8 OR across sources
        wr(2'd1, 8'h30);
        pulse(8'h10);
        chk_irq(1'b1, "R8 source4");
        pulse(8'h20);
        wr(2'd0, 8'h10);
        chk_irq(1'b1, "R8 source5 still holds");
        wr(2'd0, 8'h20);
        chk_irq(1'b0, "R8 last cleared");
        rd(2'd0, 8'h80, "R2 remaining flag");

        step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule